// File: doc/BRIEF.md
# Power Event Router with Wake Qualification

The block gathers power management event inputs from three groups (fixed, general purpose and global), synchronizes each one and captures its rising edge in a sticky status bit. Each status bit is paired with enable bits, and the enabled bits are steered onto two level interrupt outputs: a system control interrupt (SCI) and a system management interrupt (SMI). The steering rule depends on the group. Fixed events follow a single route-select control bit, except the timer carry and the firmware release event, which always go to SCI. Each general purpose event has its own SCI enable and its own SMI enable. Global events feed SMI only.

Software sees the block through an 8-bit register port with a 3-bit address. It reads the status bits, clears them by writing ones, and programs the enables. The block also issues a one-cycle resume request when a newly captured enabled event may wake the system. Whether it may depends on the current sleep state and on the power plane the event comes from.

Top module: `pwr_evt_router`

## Requirements
- R1: After synchronous reset every status, enable and control register reads 0, and `sci_o`, `smi_o` and `wake_o` are 0.
- R2: A rising edge on any event input sets its status bit. The bit is set at the third clock edge after the input rises and stays set until it is cleared. Fixed bits are 0 power button, 1 RTC alarm, 2 sleep button, 3 timer carry, 4 firmware release. General purpose bits are 0 external SMI, 1 USB resume, 2 ring, 3 battery low, 4 lid, 5 thermal. Global bits 0..7 map to `gbl_evt_i[7:0]`.
- R3: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a new edge and a clear fall on the same clock edge, the bit ends up set.
- R4: An enabled fixed event in bits 0..2 drives SCI when control bit 0 is 1 and drives SMI when it is 0.
- R5: Enabled fixed bits 3 and 4 drive SCI only, whatever the value of control bit 0.
- R6: A general purpose status bit drives SCI when its SCI enable is set and drives SMI when its SMI enable is set. These are independent, so it may drive both outputs or neither.
- R7: An enabled global status bit drives SMI and never SCI.
- R8: `sci_o` and `smi_o` are registered ORs of the routed terms. They follow a status or enable change one clock edge later.
- R9: `wake_o` pulses for one cycle, on the same edge that sets the status bit, when an enabled event from the standby plane occurs in any sleep state other than working. The standby plane is fixed bits 0 and 1 and general purpose bits 0, 2, 3 and 4. The sleep state encoding is 0 working, 1 power-on suspend, 2 suspend to RAM, 3 soft off.
- R10: Enabled main-plane events (fixed bit 3, general purpose bit 1) produce `wake_o` only in sleep state 1.
- R11: No `wake_o` occurs in sleep state 0, for a disabled event, or for events outside both planes (fixed bits 2 and 4, general purpose bit 5, all global bits). A general purpose event counts as enabled when either of its enables is set.
- R12: Register map: 0 fixed status, 1 fixed enable, 2 control (bit 0 = fixed route to SCI), 3 general purpose status, 4 general purpose SCI enable, 5 general purpose SMI enable, 6 global status, 7 global enable. `reg_rdata_o` shows the addressed register one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fix_evt_i | input | 5 | Fixed event inputs, asynchronous |
| gp_evt_i | input | 6 | General purpose event inputs, asynchronous |
| gbl_evt_i | input | 8 | Global event inputs, asynchronous |
| sleep_state_i | input | 2 | Current sleep state |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | System management interrupt level |
| wake_o | output | 1 | One-cycle resume request |

## Verification
An event input driven before edge E0 sets its status bit and raises `wake_o` at edge E2. The bench therefore samples both at the falling edge after E2 and checks at the next falling edge that the wake pulse has gone. `sci_o` and `smi_o` are due one edge after the status or enable change, so they are sampled one falling edge later. Register reads are sampled one falling edge after the address is driven. To reach a same-edge set and clear, the bench places the clear write exactly on E2 of a pending event.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int N_FIX = 5;
  localparam int N_GP  = 6;
  localparam int N_GBL = 8;

  // fixed events that ignore the route select and always raise SCI
  localparam logic [N_FIX-1:0] FIX_SCI_ONLY  = 5'b11000;
  // power plane membership for resume qualification
  localparam logic [N_FIX-1:0] FIX_STBY_MASK = 5'b00011;
  localparam logic [N_FIX-1:0] FIX_MAIN_MASK = 5'b01000;
  localparam logic [N_GP-1:0]  GP_STBY_MASK  = 6'b011101;
  localparam logic [N_GP-1:0]  GP_MAIN_MASK  = 6'b000010;

  typedef enum logic [1:0] {
    SLP_WORK = 2'd0,
    SLP_POS  = 2'd1,
    SLP_STR  = 2'd2,
    SLP_OFF  = 2'd3
  } slp_state_e;

  typedef enum logic [2:0] {
    RA_FIX_ST  = 3'd0,
    RA_FIX_EN  = 3'd1,
    RA_CTRL    = 3'd2,
    RA_GP_ST   = 3'd3,
    RA_GP_SCI  = 3'd4,
    RA_GP_SMI  = 3'd5,
    RA_GBL_ST  = 3'd6,
    RA_GBL_EN  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pwr_evt_sync.sv
module pwr_evt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= '0;
    else     pipe_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe_q[s] <= '0;
      else     pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pipe_q[STAGES-1];
  end

  assign rise_o = pipe_q[STAGES-1] & ~prev_q;

  // R2: an edge is reported for one cycle only
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/pwr_evt_status.sv
module pwr_evt_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           st_q[b] <= 1'b0;
      else if (set_i[b]) st_q[b] <= 1'b1;
      else if (clr_i[b]) st_q[b] <= 1'b0;
    end
  end

  assign st_o = st_q;

  // R2: a set bit with no clear stays set
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~clr_i) != '0) |=> (((($past(st_q) & ~$past(clr_i))) & ~st_q) == '0));
  // R3: a new edge beats a same-cycle clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_i) != '0) |=> ((st_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/pwr_evt_route.sv
module pwr_evt_route
  import pwr_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_FIX-1:0] fix_st_i,
  input  logic [N_FIX-1:0] fix_en_i,
  input  logic             to_sci_i,
  input  logic [N_GP-1:0]  gp_st_i,
  input  logic [N_GP-1:0]  gp_sci_en_i,
  input  logic [N_GP-1:0]  gp_smi_en_i,
  input  logic [N_GBL-1:0] gbl_st_i,
  input  logic [N_GBL-1:0] gbl_en_i,
  input  logic [N_FIX-1:0] fix_rise_i,
  input  logic [N_GP-1:0]  gp_rise_i,
  input  logic [1:0]       state_i,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o
);
  logic [N_FIX-1:0] fix_act, fix_sci_m, fix_smi_m;
  logic [N_GP-1:0]  gp_en_any;
  logic             sci_n, smi_n, stby_hit, main_hit, wake_n;

  always_comb begin
    fix_act   = fix_st_i & fix_en_i;
    fix_sci_m = to_sci_i ? {N_FIX{1'b1}} : FIX_SCI_ONLY;
    fix_smi_m = to_sci_i ? '0 : ~FIX_SCI_ONLY;
    sci_n = |(fix_act & fix_sci_m) | |(gp_st_i & gp_sci_en_i);
    smi_n = |(fix_act & fix_smi_m) | |(gp_st_i & gp_smi_en_i)
          | |(gbl_st_i & gbl_en_i);
    gp_en_any = gp_sci_en_i | gp_smi_en_i;
    stby_hit = |(fix_rise_i & fix_en_i & FIX_STBY_MASK)
             | |(gp_rise_i & gp_en_any & GP_STBY_MASK);
    main_hit = |(fix_rise_i & fix_en_i & FIX_MAIN_MASK)
             | |(gp_rise_i & gp_en_any & GP_MAIN_MASK);
    wake_n = (state_i != SLP_WORK && stby_hit) || (state_i == SLP_POS && main_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_o  <= 1'b0;
      smi_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      sci_o  <= sci_n;
      smi_o  <= smi_n;
      wake_o <= wake_n;
    end
  end

  // R1: outputs are clear right after reset
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sci_o && !smi_o && !wake_o));
  // R11: no resume request while working
  p_no_wake_work_r11: assert property (@(posedge clk) disable iff (rst)
    (state_i == SLP_WORK) |=> !wake_o);
  // R7: global bits alone never raise SCI
  p_gbl_no_sci_r7: assert property (@(posedge clk) disable iff (rst)
    ((fix_act == '0) && ((gp_st_i & gp_sci_en_i) == '0)) |=> !sci_o);
  // R10: main-plane events wake only from power-on suspend
  p_main_pos_only_r10: assert property (@(posedge clk) disable iff (rst)
    (!stby_hit && state_i != SLP_POS) |=> !wake_o);
  // R5: timer carry and firmware release never raise SMI
  p_fix_sci_only_r5: assert property (@(posedge clk) disable iff (rst)
    (((fix_act & ~FIX_SCI_ONLY) == '0) && ((gp_st_i & gp_smi_en_i) == '0)
      && ((gbl_st_i & gbl_en_i) == '0)) |=> !smi_o);
endmodule

// File: rtl/pwr_evt_router.sv
module pwr_evt_router
  import pwr_evt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_FIX-1:0]  fix_evt_i,
  input  logic [N_GP-1:0]   gp_evt_i,
  input  logic [N_GBL-1:0]  gbl_evt_i,
  input  logic [1:0]        sleep_state_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sci_o,
  output logic              smi_o,
  output logic              wake_o
);
  localparam int N_ALL = N_FIX + N_GP + N_GBL;

  logic [N_ALL-1:0] evt_all, rise_all;
  logic [N_FIX-1:0] fix_rise, fix_st, fix_clr, fix_en_q;
  logic [N_GP-1:0]  gp_rise, gp_st, gp_clr, gp_sci_en_q, gp_smi_en_q;
  logic [N_GBL-1:0] gbl_rise, gbl_st, gbl_clr, gbl_en_q;
  logic             to_sci_q;
  logic [DATA_W-1:0] rdata_n;

  assign evt_all = {gbl_evt_i, gp_evt_i, fix_evt_i};

  pwr_evt_sync #(.W(N_ALL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(evt_all), .rise_o(rise_all));

  assign fix_rise = rise_all[N_FIX-1:0];
  assign gp_rise  = rise_all[N_FIX+N_GP-1:N_FIX];
  assign gbl_rise = rise_all[N_ALL-1:N_FIX+N_GP];

  // write-one-to-clear strobes
  assign fix_clr = (reg_wr_i && reg_addr_i == RA_FIX_ST) ? reg_wdata_i[N_FIX-1:0] : '0;
  assign gp_clr  = (reg_wr_i && reg_addr_i == RA_GP_ST)  ? reg_wdata_i[N_GP-1:0]  : '0;
  assign gbl_clr = (reg_wr_i && reg_addr_i == RA_GBL_ST) ? reg_wdata_i[N_GBL-1:0] : '0;

  pwr_evt_status #(.W(N_FIX)) u_fix_st (
    .clk(clk), .rst(rst), .set_i(fix_rise), .clr_i(fix_clr), .st_o(fix_st));
  pwr_evt_status #(.W(N_GP)) u_gp_st (
    .clk(clk), .rst(rst), .set_i(gp_rise), .clr_i(gp_clr), .st_o(gp_st));
  pwr_evt_status #(.W(N_GBL)) u_gbl_st (
    .clk(clk), .rst(rst), .set_i(gbl_rise), .clr_i(gbl_clr), .st_o(gbl_st));

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_en_q    <= '0;
      to_sci_q    <= 1'b0;
      gp_sci_en_q <= '0;
      gp_smi_en_q <= '0;
      gbl_en_q    <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        RA_FIX_EN: fix_en_q    <= reg_wdata_i[N_FIX-1:0];
        RA_CTRL:   to_sci_q    <= reg_wdata_i[0];
        RA_GP_SCI: gp_sci_en_q <= reg_wdata_i[N_GP-1:0];
        RA_GP_SMI: gp_smi_en_q <= reg_wdata_i[N_GP-1:0];
        RA_GBL_EN: gbl_en_q    <= reg_wdata_i[N_GBL-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_n = '0;
    case (reg_addr_i)
      RA_FIX_ST: rdata_n[N_FIX-1:0] = fix_st;
      RA_FIX_EN: rdata_n[N_FIX-1:0] = fix_en_q;
      RA_CTRL:   rdata_n[0]         = to_sci_q;
      RA_GP_ST:  rdata_n[N_GP-1:0]  = gp_st;
      RA_GP_SCI: rdata_n[N_GP-1:0]  = gp_sci_en_q;
      RA_GP_SMI: rdata_n[N_GP-1:0]  = gp_smi_en_q;
      RA_GBL_ST: rdata_n[N_GBL-1:0] = gbl_st;
      RA_GBL_EN: rdata_n[N_GBL-1:0] = gbl_en_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rdata_n;
  end

  pwr_evt_route u_route (
    .clk(clk), .rst(rst),
    .fix_st_i(fix_st), .fix_en_i(fix_en_q), .to_sci_i(to_sci_q),
    .gp_st_i(gp_st), .gp_sci_en_i(gp_sci_en_q), .gp_smi_en_i(gp_smi_en_q),
    .gbl_st_i(gbl_st), .gbl_en_i(gbl_en_q),
    .fix_rise_i(fix_rise), .gp_rise_i(gp_rise), .state_i(sleep_state_i),
    .sci_o(sci_o), .smi_o(smi_o), .wake_o(wake_o));

  // R3: a clear write without a new edge empties the addressed bits
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    ((fix_clr & ~fix_rise) != '0) |=> ((fix_st & $past(fix_clr & ~fix_rise)) == '0));
  // R12: control register reads back what was written
  p_ctrl_rd_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == RA_CTRL) |=> (reg_rdata_o == {{(DATA_W-1){1'b0}}, $past(to_sci_q)}));
endmodule

// File: tb/test_pwr_evt_router.sv
module test_pwr_evt_router;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] fix_evt;
  logic [5:0] gp_evt;
  logic [7:0] gbl_evt;
  logic [1:0] slp;
  logic [2:0] addr;
  logic       wr;
  logic [7:0] wdata, rdata;
  logic       sci, smi, wake;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // bench model of software-visible state
  logic [4:0] m_fst, m_fen;
  logic       m_sel;
  logic [5:0] m_gst, m_gsci, m_gsmi;
  logic [7:0] m_bst, m_ben;

  always #5 clk = ~clk;

  pwr_evt_router i_pwr_evt_router (
    .clk(clk), .rst(rst), .fix_evt_i(fix_evt), .gp_evt_i(gp_evt), .gbl_evt_i(gbl_evt),
    .sleep_state_i(slp), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sci_o(sci), .smi_o(smi), .wake_o(wake));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sci();
    return |(m_fst & m_fen & (m_sel ? 5'h1f : 5'h18)) | |(m_gst & m_gsci);
  endfunction

  function automatic logic exp_smi();
    return |(m_fst & m_fen & (m_sel ? 5'h00 : 5'h07)) | |(m_gst & m_gsmi) | |(m_bst & m_ben);
  endfunction

  function automatic logic exp_wake(input logic [4:0] f, input logic [5:0] g, input logic [1:0] s);
    logic [5:0] gen;
    logic st, mn;
    gen = m_gsci | m_gsmi;
    st = |(f & m_fen & 5'h03) | |(g & gen & 6'h1d);
    mn = |(f & m_fen & 5'h08) | |(g & gen & 6'h02);
    return (s != 2'd0 && st) || (s == 2'd1 && mn);
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic chk_out(input string req);
    @(negedge clk);
    chk({req, " sci"}, sci, exp_sci());
    chk({req, " smi"}, smi, exp_smi());
  endtask

  // pulse inputs; status and wake due at edge E2, sci/smi at E3
  task automatic fire(input logic [4:0] f, input logic [5:0] g, input logic [7:0] b);
    logic ew;
    @(negedge clk); fix_evt = f; gp_evt = g; gbl_evt = b;
    @(negedge clk); fix_evt = '0; gp_evt = '0; gbl_evt = '0;
    @(negedge clk);
    @(negedge clk);
    ew = exp_wake(f, g, slp);
    chk("R9/R10/R11 wake", wake, ew);
    m_fst |= f; m_gst |= g; m_bst |= b;
    @(negedge clk);
    chk("R9 wake one cycle", wake, 0);
    chk("R8 sci", sci, exp_sci());
    chk("R8 smi", smi, exp_smi());
  endtask

  task automatic chk_status(input string req);
    logic [7:0] d;
    rd_reg(3'd0, d); chk({req, " fixed status"}, d, {3'b0, m_fst});
    rd_reg(3'd3, d); chk({req, " gp status"}, d, {2'b0, m_gst});
    rd_reg(3'd6, d); chk({req, " global status"}, d, m_bst);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    rst = 1'b1; fix_evt = '0; gp_evt = '0; gbl_evt = '0; slp = 2'd0;
    addr = '0; wr = 1'b0; wdata = '0;
    m_fst = '0; m_fen = '0; m_sel = 0; m_gst = '0; m_gsci = '0; m_gsmi = '0;
    m_bst = '0; m_ben = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 all addresses
    chk("R1 sci", sci, 0); chk("R1 smi", smi, 0); chk("R1 wake", wake, 0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(a[2:0], d); chk("R1 reg zero", d, 0);
    end

    // R4 fixed route to SMI, then to SCI
    wr_reg(3'd1, 8'h1f); m_fen = 5'h1f;
    fire(5'h04, '0, '0);
    chk("R4 sleep button to SMI", smi, 1);
    wr_reg(3'd2, 8'h01); m_sel = 1;
    chk_out("R4 route select");
    chk("R4 sleep button to SCI", sci, 1);
    rd_reg(3'd2, d); chk("R12 control readback", d, 1);
    // R3 write 0 ignored, write 1 clears
    wr_reg(3'd0, 8'h00); chk_status("R3 write zero");
    wr_reg(3'd0, 8'h04); m_fst = '0; chk_out("R3 clear"); chk_status("R3 clear");
    // R5 timer carry always SCI
    wr_reg(3'd2, 8'h00); m_sel = 0;
    fire(5'h08, '0, '0);
    chk("R5 timer carry SCI", sci, 1); chk("R5 timer carry no SMI", smi, 0);
    wr_reg(3'd0, 8'h08); m_fst = '0;
    // R3 set wins over clear on the same edge
    fire(5'h02, '0, '0);
    @(negedge clk); fix_evt = 5'h01;
    @(negedge clk); fix_evt = '0;
    @(negedge clk); addr = 3'd0; wdata = 8'h03; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    m_fst = 5'h01;
    chk_status("R3 set beats clear");
    wr_reg(3'd0, 8'h1f); m_fst = '0;
    // R6 GP both routes, R7 global SMI only
    wr_reg(3'd4, 8'h20); m_gsci = 6'h20;
    wr_reg(3'd5, 8'h20); m_gsmi = 6'h20;
    fire('0, 6'h20, '0);
    chk("R6 thermal SCI", sci, 1); chk("R6 thermal SMI", smi, 1);
    wr_reg(3'd3, 8'h3f); m_gst = '0;
    wr_reg(3'd7, 8'h80); m_ben = 8'h80;
    fire('0, '0, 8'h80);
    chk("R7 software SMI", smi, 1); chk("R7 no SCI", sci, 0);
    wr_reg(3'd6, 8'hff); m_bst = '0;
    // R10 main plane: USB resume in suspend to RAM then in POS
    wr_reg(3'd4, 8'h02); m_gsci = 6'h02;
    slp = 2'd2; fire('0, 6'h02, '0); chk("R10 no wake in S3", wake, 0);
    slp = 2'd1; fire('0, 6'h02, '0);
    // R9 standby plane in soft off; R11 working
    slp = 2'd3; fire(5'h01, '0, '0);
    slp = 2'd0; fire(5'h01, '0, '0);
    wr_reg(3'd0, 8'h1f); m_fst = '0; wr_reg(3'd3, 8'h3f); m_gst = '0;

    // randomised phase
    for (int it = 0; it < 60; it++) begin
      logic [7:0] r;
      slp = 2'($urandom % 4);
      r = 8'($urandom); wr_reg(3'd1, r); m_fen = r[4:0];
      r = 8'($urandom); wr_reg(3'd2, r); m_sel = r[0];
      r = 8'($urandom); wr_reg(3'd4, r); m_gsci = r[5:0];
      r = 8'($urandom); wr_reg(3'd5, r); m_gsmi = r[5:0];
      r = 8'($urandom); wr_reg(3'd7, r); m_ben = r;
      chk_out("R8 enable change");
      fire(5'($urandom), 6'($urandom), 8'($urandom));
      chk_status("R2 random capture");
      r = 8'($urandom); wr_reg(3'd0, r); m_fst &= ~r[4:0];
      r = 8'($urandom); wr_reg(3'd3, r); m_gst &= ~r[5:0];
      r = 8'($urandom); wr_reg(3'd6, r); m_bst &= ~r;
      chk_out("R3 random clear");
      chk_status("R3 random clear");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule